// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block divides the system clock into time quanta and walks each bit period through three segments. The first is a one-quantum synchronisation segment. The second is one merged span that covers propagation and phase 1. The third is phase 2. The block emits a strobe where the receive line is sampled, the sampled level, a strobe at each bit boundary and the current segment code. A 16-bit packed timing word sets it up. Each field in the word holds its value minus one. A prescaler extension input widens the clock divider beyond the 6-bit field in the word.

The block follows the transmitter's clock by watching the receive line for recessive-to-dominant transitions (1 to 0). An edge that arrives late, inside the merged span, stretches that span. An edge that arrives early, inside phase 2, trims phase 2. Either correction is bounded by the programmed jump width. Only one correction is made per bit, and edges inside the sync segment are ignored. A hard-sync request restarts the bit with no limit. Frame logic sits downstream and consumes the strobes.

The segment state machine has three states: `SEG_SYNC` (code 0), `SEG_T1` (code 1, propagation plus phase 1) and `SEG_T2` (code 2, phase 2). It has four transitions:
- sync-done: `SEG_SYNC`→`SEG_T1` on the quantum tick.
- sample: `SEG_T1`→`SEG_T2` on the tick that ends the last quantum of the span, possibly lengthened.
- bit-end: `SEG_T2`→`SEG_SYNC` on the tick that ends the last quantum of phase 2, possibly shortened.
- hard-restart: any state→`SEG_SYNC` on a hard-sync request.

Top module: `can_bit_timer`

## Requirements
- R1: The timing word is decoded as follows: bits 14:12 hold phase 2 minus one, bits 11:8 hold the merged propagation-plus-phase-1 length minus one, bits 7:6 hold jump width minus one, and bits 5:0 hold the prescaler minus one. Bit 15 is ignored. With the word 0x5EC0 and a zero extension the bit lasts 22 quanta of one clock each.
- R2: A quantum lasts ({extension, bits 5:0} + 1) clock cycles, and `tq_tick_o` is high for exactly one cycle per quantum, so a plain bit shows exactly as many ticks as it has quanta.
- R3: Segments run in the order code 0, 1, 2, and the sync segment lasts one quantum. The sample strobe pulses for one cycle, 1 + (merged length) quanta after the bit-start strobe. The two strobes never coincide.
- R4: A programmed phase 2 below 2 quanta (field value 0) is treated as 2 quanta.
- R5: A 1→0 edge in the merged span during its k-th quantum lengthens that span by min(k, jump width) quanta, which delays both the sample and the bit end.
- R6: A 1→0 edge in phase 2 during its m-th quantum shortens phase 2 by min(phase2 − m, jump width) quanta.
- R7: A 1→0 edge in the sync segment changes no timing, and after one correction in a bit any further edge in that bit changes no timing.
- R8: A hard-sync request held high in one cycle makes the next cycle a bit-start with segment code 0, regardless of jump width.
- R9: During reset the segment code is 0, both strobes are low and the sampled value is 1.
- R10: The sampled value is the receive line level at the clock edge that ends the merged span. It is held until the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bt_cfg_i | input | 16 | Packed bit-timing word (minus-one fields) |
| brp_ext_i | input | BRPE_W | Prescaler extension, upper divider bits |
| rx_i | input | 1 | Receive line, 1 recessive, 0 dominant |
| hsync_i | input | 1 | Hard-sync request |
| tq_tick_o | output | 1 | One-cycle pulse at the last clock of each quantum |
| sample_o | output | 1 | Sample strobe |
| rx_bit_o | output | 1 | Sampled bit value |
| bit_start_o | output | 1 | Bit-boundary strobe |
| seg_o | output | 2 | Current segment code |

## Verification
The bench observes the outputs and counts everything in cycles from the cycle in which a bit-start pulse is first seen, which is one cycle after the registering edge:
- The sample pulse is due (1 + merged length + correction) × prescaler cycles later.
- The next bit-start is due one full, possibly corrected, period later.
- After a hard-sync request, the bit-start pulse appears exactly one cycle later.

The driver injects edges a fixed number of cycles after that first bit-start cycle, so each edge lands in a known quantum. It queues the expected period, sample offset, sampled level and tick count. A negedge monitor compares them at the very cycle each strobe is seen and pops the entry when its bit ends.

// File: rtl/can_btm_pkg.sv
package can_btm_pkg;
    // Packed timing word layout (minus-one fields)
    localparam int CFG_W   = 16;
    localparam int BRP_LSB = 0;
    localparam int BRP_W   = 6;
    localparam int SJW_LSB = 6;
    localparam int SJW_W   = 2;
    localparam int T1_LSB  = 8;
    localparam int T1_W    = 4;
    localparam int T2_LSB  = 12;
    localparam int T2_W    = 3;
    localparam int PH2_MIN = 2;
    // quanta counter must hold the longest stretched merged span
    localparam int QW = $clog2((1 << T1_W) + (1 << SJW_W) + 1);

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_T1   = 2'd1,
        SEG_T2   = 2'd2
    } seg_e;
endpackage

// File: rtl/cbt_cfg_decode.sv
module cbt_cfg_decode
    import can_btm_pkg::*;
#(
    parameter int BRPE_W = 4,
    localparam int DIV_W = BRPE_W + BRP_W
) (
    input  logic [CFG_W-1:0]  cfg_i,
    input  logic [BRPE_W-1:0] brpe_i,
    output logic [DIV_W-1:0]  div_max_o,
    output logic [QW-1:0]     t1_len_o,
    output logic [QW-1:0]     t2_len_o,
    output logic [QW-1:0]     sjw_o
);
    logic [QW-1:0] t2_raw;
    logic          unused_cfg_msb;

    assign unused_cfg_msb = cfg_i[CFG_W-1];

    always_comb begin
        div_max_o = {brpe_i, cfg_i[BRP_LSB +: BRP_W]};
        t1_len_o  = QW'(cfg_i[T1_LSB +: T1_W]) + QW'(1);
        t2_raw    = QW'(cfg_i[T2_LSB +: T2_W]) + QW'(1);
        t2_len_o  = (t2_raw < QW'(PH2_MIN)) ? QW'(PH2_MIN) : t2_raw;
        sjw_o     = QW'(cfg_i[SJW_LSB +: SJW_W]) + QW'(1);
    end
endmodule

// File: rtl/cbt_tq_div.sv
module cbt_tq_div #(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_max_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q >= div_max_i);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i || tick_o) cnt_q <= '0;
        else                             cnt_q <= cnt_q + DIV_W'(1);
    end

    // R2: with a divider above one, a tick is never followed directly by another
    assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(tick_o) && !$past(restart_i) && $stable(div_max_i) && div_max_i != '0)
        |-> !tick_o);
endmodule

// File: rtl/cbt_fall_det.sv
module cbt_fall_det (
    input  logic clk_i,
    input  logic rst_i,
    input  logic rx_i,
    output logic fall_o
);
    logic rx_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) rx_q <= 1'b1;
        else       rx_q <= rx_i;
    end

    assign fall_o = rx_q & ~rx_i;
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import can_btm_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          tick_i,
    input  logic          hsync_i,
    input  logic          fall_i,
    input  logic          rx_i,
    input  logic [QW-1:0] t1_len_i,
    input  logic [QW-1:0] t2_len_i,
    input  logic [QW-1:0] sjw_i,
    output logic          sample_o,
    output logic          rx_bit_o,
    output logic          bit_start_o,
    output seg_e          seg_o
);
    seg_e          state_q, state_d;
    logic [QW-1:0] cnt_q, cnt_d;
    logic [QW-1:0] ext_q, ext_d, ext_now;
    logic [QW-1:0] shr_q, shr_d, shr_now;
    logic          done_q, done_d;
    logic          edge_ok;
    logic [QW-1:0] lim1, lim2, left2;
    logic          fire_samp, fire_start;

    // phase-error evaluation for the current cycle
    always_comb begin
        edge_ok = fall_i && !done_q && (state_q != SEG_SYNC);
        left2   = (cnt_q >= t2_len_i) ? '0 : (t2_len_i - cnt_q);
        ext_now = ext_q;
        shr_now = shr_q;
        if (edge_ok && state_q == SEG_T1) ext_now = (cnt_q < sjw_i) ? cnt_q : sjw_i;
        if (edge_ok && state_q == SEG_T2) shr_now = (left2 < sjw_i) ? left2 : sjw_i;
        lim1 = t1_len_i + ext_now;
        lim2 = t2_len_i - shr_now;
    end

    // next-state logic
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        ext_d      = ext_now;
        shr_d      = shr_now;
        done_d     = done_q | edge_ok;
        fire_samp  = 1'b0;
        fire_start = 1'b0;
        if (hsync_i) begin
            state_d    = SEG_SYNC;
            cnt_d      = '0;
            ext_d      = '0;
            shr_d      = '0;
            done_d     = 1'b0;
            fire_start = 1'b1;
        end else if (tick_i) begin
            unique case (state_q)
                SEG_SYNC: begin
                    state_d = SEG_T1;
                    cnt_d   = QW'(1);
                end
                SEG_T1: begin
                    if (cnt_q >= lim1) begin
                        state_d   = SEG_T2;
                        cnt_d     = QW'(1);
                        fire_samp = 1'b1;
                    end else begin
                        cnt_d = cnt_q + QW'(1);
                    end
                end
                SEG_T2: begin
                    if (cnt_q >= lim2) begin
                        state_d    = SEG_SYNC;
                        cnt_d      = '0;
                        ext_d      = '0;
                        shr_d      = '0;
                        done_d     = 1'b0;
                        fire_start = 1'b1;
                    end else begin
                        cnt_d = cnt_q + QW'(1);
                    end
                end
                default: state_d = SEG_SYNC;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SEG_SYNC;
            cnt_q   <= '0;
            ext_q   <= '0;
            shr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ext_q   <= ext_d;
            shr_q   <= shr_d;
            done_q  <= done_d;
        end
    end

    // output register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sample_o    <= 1'b0;
            rx_bit_o    <= 1'b1;
            bit_start_o <= 1'b0;
        end else begin
            sample_o    <= fire_samp;
            bit_start_o <= fire_start;
            if (fire_samp) rx_bit_o <= rx_i;
        end
    end

    assign seg_o = state_q;

    assert_sync_exit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(hsync_i) && $past(state_q) == SEG_SYNC) |-> state_q inside {SEG_SYNC, SEG_T1});
    assert_t1_exit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(hsync_i) && $past(state_q) == SEG_T1) |-> state_q inside {SEG_T1, SEG_T2});
    assert_t2_exit_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(hsync_i) && $past(state_q) == SEG_T2) |-> state_q inside {SEG_T2, SEG_SYNC});
    assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(sample_o && bit_start_o));
    assert_tick_gate_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q != $past(state_q)) |-> $past(tick_i || hsync_i));
    assert_one_resync_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(done_q) && !$past(hsync_i) && state_q != SEG_SYNC) |-> ($stable(ext_q) && $stable(shr_q)));
    assert_hard_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(hsync_i) |-> (state_q == SEG_SYNC && bit_start_o));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_btm_pkg::*;
#(
    parameter int BRPE_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [15:0]       bt_cfg_i,
    input  logic [BRPE_W-1:0] brp_ext_i,
    input  logic              rx_i,
    input  logic              hsync_i,
    output logic              tq_tick_o,
    output logic              sample_o,
    output logic              rx_bit_o,
    output logic              bit_start_o,
    output logic [1:0]        seg_o
);
    localparam int DIV_W = BRPE_W + BRP_W;

    logic [DIV_W-1:0] div_max;
    logic [QW-1:0]    t1_len, t2_len, sjw;
    logic             tick, fall;
    seg_e             seg;

    cbt_cfg_decode #(.BRPE_W(BRPE_W)) u_dec (
        .cfg_i    (bt_cfg_i),
        .brpe_i   (brp_ext_i),
        .div_max_o(div_max),
        .t1_len_o (t1_len),
        .t2_len_o (t2_len),
        .sjw_o    (sjw)
    );

    cbt_tq_div #(.DIV_W(DIV_W)) u_div (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .restart_i(hsync_i),
        .div_max_i(div_max),
        .tick_o   (tick)
    );

    cbt_fall_det u_edge (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .rx_i  (rx_i),
        .fall_o(fall)
    );

    cbt_seg_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .tick_i     (tick),
        .hsync_i    (hsync_i),
        .fall_i     (fall),
        .rx_i       (rx_i),
        .t1_len_i   (t1_len),
        .t2_len_i   (t2_len),
        .sjw_i      (sjw),
        .sample_o   (sample_o),
        .rx_bit_o   (rx_bit_o),
        .bit_start_o(bit_start_o),
        .seg_o      (seg)
    );

    assign tq_tick_o = tick;
    assign seg_o     = seg;
endmodule

// File: tb/tb_can_bit_timer.sv
`timescale 1ns/1ps
module tb_can_bit_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg = 16'h5EC0;
    logic [3:0]  brpe = 4'd0;
    logic        rx = 1'b1;
    logic        hsync = 1'b0;
    logic        tq_tick, sample, rx_bit, bit_start;
    logic [1:0]  seg;

    always #2 clk = ~clk;

    can_bit_timer #(.BRPE_W(4)) dut (
        .clk_i(clk), .rst_i(rst), .bt_cfg_i(cfg), .brp_ext_i(brpe),
        .rx_i(rx), .hsync_i(hsync), .tq_tick_o(tq_tick), .sample_o(sample),
        .rx_bit_o(rx_bit), .bit_start_o(bit_start), .seg_o(seg)
    );

    typedef struct {
        int    idx;
        int    period;
        int    soff;
        int    sval;
        int    quanta;
        string tag;
    } sb_item_t;

    sb_item_t q[$];
    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int start_cyc = 0;
    int cur_idx = 0;
    int tick_cnt = 0;
    bit samp_seen = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // monitor: compares strobes against queued expectations
    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (sample && q.size() > 0 && q[0].idx == cur_idx && q[0].soff >= 0) begin
                samp_seen = 1'b1;
                chk(cyc - start_cyc == q[0].soff, {q[0].tag, " sample offset R3"}, cyc - start_cyc, q[0].soff);
                chk(rx_bit == q[0].sval[0], "R10 sampled value", int'(rx_bit), q[0].sval);
            end
            if (bit_start) begin
                if (q.size() > 0 && q[0].idx == cur_idx) begin
                    chk(cyc - start_cyc == q[0].period, {q[0].tag, " bit period"}, cyc - start_cyc, q[0].period);
                    if (q[0].soff >= 0)
                        chk(samp_seen, {q[0].tag, " sample present R3"}, int'(samp_seen), 1);
                    if (q[0].quanta >= 0)
                        chk(tick_cnt == q[0].quanta, "R2 ticks per bit", tick_cnt, q[0].quanta);
                    void'(q.pop_front());
                end
                cur_idx++;
                start_cyc = cyc;
                tick_cnt = 0;
                samp_seen = 1'b0;
                chk(seg == 2'd0, "R3 segment at bit start", int'(seg), 0);
            end
            if (tq_tick) tick_cnt++;
        end
    end

    task automatic wait_start();
        do @(negedge clk); while (!bit_start);
        #1;
    endtask

    // driver: queue expectation, then inject edges at cycle offsets from bit start
    task automatic run_bit(input int fa, input int ra, input int fb, input int hs,
                           input int per, input int so, input int sv, input int qn,
                           input string tg);
        sb_item_t it;
        int last;
        wait_start();
        it.idx = cur_idx; it.period = per; it.soff = so; it.sval = sv;
        it.quanta = qn; it.tag = tg;
        q.push_back(it);
        rx = 1'b1;
        if (fa == 0) rx = 1'b0;
        last = fa;
        if (ra > last) last = ra;
        if (fb > last) last = fb;
        if (hs >= 0 && hs + 1 > last) last = hs + 1;
        for (int off = 1; off <= last; off++) begin
            @(negedge clk);
            if (off == fa) rx = 1'b0;
            if (off == ra) rx = 1'b1;
            if (off == fb) rx = 1'b0;
            if (off == hs) hsync = 1'b1;
            if (hs >= 0 && off == hs + 1) hsync = 1'b0;
        end
    endtask

    task automatic reconfig(input logic [15:0] c, input logic [3:0] e);
        wait_start();
        cfg = c; brpe = e; rx = 1'b1; hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(seg == 2'd0, "R9 reset segment", int'(seg), 0);
        chk(!bit_start, "R9 reset bit_start", int'(bit_start), 0);
        chk(!sample, "R9 reset sample", int'(sample), 0);
        chk(rx_bit, "R9 reset rx_bit", int'(rx_bit), 1);
        @(negedge clk);
        rst = 1'b0;
        // 0x5EC0, one clock per quantum
        run_bit(-1, -1, -1, -1, 22, 16, 1, 22, "R1 plain");
        run_bit(2, -1, -1, -1, 24, 18, 0, 24, "R5 late k2");
        run_bit(10, -1, -1, -1, 26, 20, 0, 26, "R5 late capped");
        run_bit(16, -1, -1, -1, 18, 16, 1, 18, "R6 early m1");
        run_bit(19, -1, -1, -1, 20, 16, 1, 20, "R6 early m4");
        run_bit(0, -1, -1, -1, 22, 16, 0, 22, "R7 sync edge");
        run_bit(2, 5, 8, -1, 24, 18, 0, 24, "R7 second edge");
        run_bit(-1, -1, -1, 5, 6, -1, 1, -1, "R8 hard sync");
        run_bit(-1, -1, -1, -1, 22, 16, 1, 22, "R1 after restart");
        // jump width of one quantum
        reconfig(16'h5E00, 4'd0);
        run_bit(3, -1, -1, -1, 23, 17, 0, 23, "R5 sjw1");
        // phase 2 field 0 -> 2 quanta, merged span 4
        reconfig(16'h0300, 4'd0);
        run_bit(-1, -1, -1, -1, 7, 5, 1, 7, "R4 min phase2");
        // prescaler field 2 -> 3 clocks per quantum
        reconfig(16'h5EC2, 4'd0);
        run_bit(-1, -1, -1, -1, 66, 48, 1, 22, "R2 brp3");
        // extension 1 -> 65 clocks per quantum
        reconfig(16'h5EC0, 4'd1);
        run_bit(-1, -1, -1, -1, 1430, 1040, 1, 22, "R2 ext");
        wait_start();
        chk(q.size() == 0, "R3 all bits seen", q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule